// File: doc/BRIEF.md
# Power-Up Configuration Sequencer

This block sequences a device from power-on to user operation when its configuration bitstream lives in an external serial flash. A power-on-reset timer runs first. Its length is picked by a select input: one setting gives a long standard window and the other a short fast window. While the timer runs, the status and done handshakes are held low and every user I/O is tri-stated. When the timer expires the block releases the status line. It then waits in a reset stage for as long as the external configuration request or the status line is held low.

Once both lines are high, the block enters the configuration stage. It lowers chip select and sends a read command with a zero start address on a four-wire serial link. It then clocks in a fixed number of bitstream bits and hands each one out with a one-cycle valid strobe. After the last bit it releases the done line, waits a fixed initialization count, takes user I/O out of tri-state and raises a user-mode flag. If the configuration request drops during configuration or initialization, the block aborts and returns to the reset stage. Time is measured in ticks, where one tick is a parameterised number of clock cycles standing for one millisecond.

Top module: `cfg_sequencer`

## Requirements
- R1: For the power-on window after reset, status_oe and done_oe are 1 (both lines driven low), io_tristate is 1 and io_pullup_en is 0. The window lasts POR_FAST_TICKS ticks (4 to 12) when por_fast is 1 and POR_STD_TICKS ticks (100 to 300) when por_fast is 0. One tick is TICK_DIV clock cycles.
- R2: When the window ends, status_oe drops to 0. The block stays in the reset stage, with cs_n high, while ncfg_req or status_in is 0. In that stage status_oe is 1 exactly while ncfg_req is 0.
- R3: io_pullup_en equals the inverse of pullup_n in the reset, configuration and initialization stages. It is 0 during the power-on window and in user mode.
- R4: In the configuration stage cs_n is 0. The first 32 bits on cmd_out are the read word 0x03 followed by 24 zero address bits, sent MSB first. cmd_out changes only on falling sclk edges, so each bit is stable at the rising edge that follows.
- R5: After the command, CFG_BITS bits of data_in are sampled on successive rising sclk edges. Each one appears on bit_out, in arrival order, with bit_valid high for one clock cycle.
- R6: sclk is high and low for SCLK_HALF_FAST clock cycles each when mode_fast is 1 at the start of the stage, and for SCLK_HALF_STD cycles each when mode_fast is 0.
- R7: After the last bit, cs_n returns to 1 and done_oe drops to 0. io_tristate stays 1 for exactly INIT_CYCLES cycles with done_oe at 0. Then io_tristate goes to 0 and user_mode goes to 1.
- R8: If ncfg_req is 0 in the configuration or initialization stage, then on the next cycle cs_n is 1, done_oe is 1, status_oe is 1 and user_mode is 0. Once the request rises again, a new frame starts with the full command.
- R9: In user mode, a low ncfg_req leaves user_mode at 1, io_tristate at 0 and status_oe at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| por_fast | input | 1 | 1 selects the fast power-on window, 0 selects the standard window |
| ncfg_req | input | 1 | External configuration request, active low |
| status_in | input | 1 | Sensed level of the open-drain status line |
| pullup_n | input | 1 | 0 enables weak pull-ups during the reset and configuration stages |
| mode_fast | input | 1 | 1 selects the fast serial clock rate |
| status_oe | output | 1 | 1 drives the status line low |
| done_oe | output | 1 | 1 drives the done line low |
| io_tristate | output | 1 | 1 holds user I/O tri-stated |
| io_pullup_en | output | 1 | Weak pull-up enable for user I/O |
| user_mode | output | 1 | High once the device is in user operation |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Flash chip select, active low |
| cmd_out | output | 1 | Command and address bits to the flash |
| data_in | input | 1 | Bitstream bits from the flash |
| bit_out | output | 1 | Last bitstream bit received |
| bit_valid | output | 1 | One-cycle strobe for bit_out |

## Verification
The assertions assume the flash changes data_in only after a falling sclk edge, so the bit sampled at each rising edge is the one it intended. They also assume that por_fast and mode_fast are steady while the timer runs or a frame is in progress. The stimulus models the flash from the observed sclk falls and sets the next bit right after each fall. It changes the two select inputs only while reset is held. Request drops are applied in the reset, configuration, initialization and user stages, so each abort and no-effect path is exercised.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  typedef enum logic [2:0] {
    ST_POR    = 3'd0,
    ST_RESET  = 3'd1,
    ST_CONFIG = 3'd2,
    ST_INIT   = 3'd3,
    ST_USER   = 3'd4
  } stage_e;

  localparam int unsigned CMD_BITS = 32;
  localparam logic [CMD_BITS-1:0] READ_WORD = 32'h0300_0000;
endpackage

// File: rtl/por_timer.sv
module por_timer #(
  parameter int unsigned TICK_DIV   = 40000,
  parameter int unsigned STD_TICKS  = 150,
  parameter int unsigned FAST_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_sel,
  output logic expired
);
  localparam int unsigned MAX_TICKS = (STD_TICKS > FAST_TICKS) ? STD_TICKS : FAST_TICKS;
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned TW = $clog2(MAX_TICKS + 1);

  logic [PW-1:0] presc_q, presc_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] target;
  logic          tick;

  assign target  = fast_sel ? TW'(FAST_TICKS) : TW'(STD_TICKS);
  assign tick    = (presc_q == PW'(TICK_DIV - 1));
  assign expired = (cnt_q >= target);

  always_comb begin
    presc_d = presc_q;
    cnt_d   = cnt_q;
    if (!expired) begin
      if (tick) begin
        presc_d = '0;
        cnt_d   = cnt_q + 1'b1;
      end else begin
        presc_d = presc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else begin
      presc_q <= presc_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_TIMER_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(MAX_TICKS)); // R1
  AST_TIMER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired); // R1
endmodule

// File: rtl/flash_reader.sv
module flash_reader
  import cfgseq_pkg::*;
#(
  parameter int unsigned CFG_BITS  = 256,
  parameter int unsigned HALF_STD  = 4,
  parameter int unsigned HALF_FAST = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic fast_clk,
  output logic sclk,
  output logic cs_n,
  output logic cmd_out,
  input  logic data_in,
  output logic bit_out,
  output logic bit_valid,
  output logic finished
);
  localparam int unsigned TOTAL = CMD_BITS + CFG_BITS;
  localparam int unsigned BW    = $clog2(TOTAL + 1);
  localparam int unsigned HMAX  = (HALF_STD > HALF_FAST) ? HALF_STD : HALF_FAST;
  localparam int unsigned HW    = $clog2(HMAX + 1);

  logic                active_q, active_d;
  logic                sclk_q, sclk_d;
  logic                fast_q, fast_d;
  logic [HW-1:0]       half_q, half_d;
  logic [BW-1:0]       bits_q, bits_d;
  logic [CMD_BITS-1:0] sh_q, sh_d;
  logic                bit_q, bit_d;
  logic                valid_q, valid_d;
  logic                fin_q, fin_d;
  logic [HW-1:0]       half_last;
  logic                edge_now;

  assign half_last = fast_q ? HW'(HALF_FAST - 1) : HW'(HALF_STD - 1);
  assign edge_now  = active_q && (half_q == half_last);

  always_comb begin
    active_d = active_q;
    sclk_d   = sclk_q;
    fast_d   = fast_q;
    half_d   = half_q;
    bits_d   = bits_q;
    sh_d     = sh_q;
    bit_d    = bit_q;
    valid_d  = 1'b0;
    fin_d    = 1'b0;
    if (abort) begin
      active_d = 1'b0;
      sclk_d   = 1'b0;
      half_d   = '0;
    end else if (start) begin
      active_d = 1'b1;
      sclk_d   = 1'b0;
      half_d   = '0;
      bits_d   = '0;
      sh_d     = READ_WORD;
      fast_d   = fast_clk;
    end else if (active_q) begin
      if (edge_now) begin
        half_d = '0;
        sclk_d = ~sclk_q;
        if (!sclk_q) begin
          if (bits_q >= BW'(CMD_BITS)) begin
            bit_d   = data_in;
            valid_d = 1'b1;
          end
        end else begin
          sh_d = {sh_q[CMD_BITS-2:0], 1'b0};
          if (bits_q == BW'(TOTAL - 1)) begin
            active_d = 1'b0;
            fin_d    = 1'b1;
          end else begin
            bits_d = bits_q + 1'b1;
          end
        end
      end else begin
        half_d = half_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      fast_q   <= 1'b0;
      half_q   <= '0;
      bits_q   <= '0;
      sh_q     <= '0;
      bit_q    <= 1'b0;
      valid_q  <= 1'b0;
      fin_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      sclk_q   <= sclk_d;
      fast_q   <= fast_d;
      half_q   <= half_d;
      bits_q   <= bits_d;
      sh_q     <= sh_d;
      bit_q    <= bit_d;
      valid_q  <= valid_d;
      fin_q    <= fin_d;
    end
  end

  assign sclk      = sclk_q;
  assign cs_n      = ~active_q;
  assign cmd_out   = sh_q[CMD_BITS-1];
  assign bit_out   = bit_q;
  assign bit_valid = valid_q;
  assign finished  = fin_q;

  AST_CMD_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(cmd_out)); // R4
  AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (sclk_q && !$past(sclk_q))); // R5
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk_q); // R4
endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
  import cfgseq_pkg::*;
#(
  parameter int unsigned TICK_DIV       = 40000,
  parameter int unsigned POR_STD_TICKS  = 150,
  parameter int unsigned POR_FAST_TICKS = 6,
  parameter int unsigned CFG_BITS       = 256,
  parameter int unsigned INIT_CYCLES    = 16,
  parameter int unsigned SCLK_HALF_STD  = 4,
  parameter int unsigned SCLK_HALF_FAST = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_fast,
  input  logic ncfg_req,
  input  logic status_in,
  input  logic pullup_n,
  input  logic mode_fast,
  output logic status_oe,
  output logic done_oe,
  output logic io_tristate,
  output logic io_pullup_en,
  output logic user_mode,
  output logic sclk,
  output logic cs_n,
  output logic cmd_out,
  input  logic data_in,
  output logic bit_out,
  output logic bit_valid
);
  localparam int unsigned IW = $clog2(INIT_CYCLES + 1);

  logic [1:0]    rsync_q;
  logic          srst_n;
  stage_e        stage_q, stage_d;
  logic [IW-1:0] init_q, init_d;
  logic          por_expired;
  logic          rd_finished;
  logic          go_cfg;
  logic          abort_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  por_timer #(
    .TICK_DIV  (TICK_DIV),
    .STD_TICKS (POR_STD_TICKS),
    .FAST_TICKS(POR_FAST_TICKS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (srst_n),
    .fast_sel(por_fast),
    .expired (por_expired)
  );

  assign go_cfg   = (stage_q == ST_RESET) && ncfg_req && status_in;
  assign abort_rd = (stage_q == ST_CONFIG) && !ncfg_req;

  flash_reader #(
    .CFG_BITS (CFG_BITS),
    .HALF_STD (SCLK_HALF_STD),
    .HALF_FAST(SCLK_HALF_FAST)
  ) u_reader (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (go_cfg),
    .abort    (abort_rd),
    .fast_clk (mode_fast),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .cmd_out  (cmd_out),
    .data_in  (data_in),
    .bit_out  (bit_out),
    .bit_valid(bit_valid),
    .finished (rd_finished)
  );

  always_comb begin
    stage_d = stage_q;
    case (stage_q)
      ST_POR:    if (por_expired) stage_d = ST_RESET;
      ST_RESET:  if (go_cfg) stage_d = ST_CONFIG;
      ST_CONFIG: begin
        if (!ncfg_req)        stage_d = ST_RESET;
        else if (rd_finished) stage_d = ST_INIT;
      end
      ST_INIT: begin
        if (!ncfg_req)                         stage_d = ST_RESET;
        else if (init_q == IW'(INIT_CYCLES-1)) stage_d = ST_USER;
      end
      ST_USER:   stage_d = ST_USER;
      default:   stage_d = ST_POR;
    endcase
  end

  assign init_d = (stage_q == ST_INIT) ? init_q + 1'b1 : '0;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      stage_q <= ST_POR;
      init_q  <= '0;
    end else begin
      stage_q <= stage_d;
      init_q  <= init_d;
    end
  end

  assign status_oe    = (stage_q == ST_POR) || ((stage_q == ST_RESET) && !ncfg_req);
  assign done_oe      = (stage_q != ST_INIT) && (stage_q != ST_USER);
  assign io_tristate  = (stage_q != ST_USER);
  assign user_mode    = (stage_q == ST_USER);
  assign io_pullup_en = !pullup_n && (stage_q != ST_POR) && (stage_q != ST_USER);

  AST_POR_HOLDS_LOW: assert property (@(posedge clk) disable iff (!srst_n)
    !por_expired |-> (status_oe && done_oe && io_tristate && !io_pullup_en)); // R1
  AST_CS_ONLY_IN_CONFIG: assert property (@(posedge clk) disable iff (!srst_n)
    (stage_q != ST_CONFIG) |-> cs_n); // R4
  AST_ABORT_RETURNS: assert property (@(posedge clk) disable iff (!srst_n)
    (((stage_q == ST_CONFIG) || (stage_q == ST_INIT)) && !ncfg_req) |=> (cs_n && done_oe && !user_mode)); // R8
  AST_DONE_BEFORE_USER: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(user_mode) |-> $past(!done_oe)); // R7
  AST_USER_HOLDS: assert property (@(posedge clk) disable iff (!srst_n)
    user_mode |=> user_mode); // R9
endmodule

// File: tb/sim_cfg_sequencer.sv
module sim_cfg_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int STD_T      = 150;
  localparam int FAST_T     = 6;
  localparam int NBITS      = 40;
  localparam int INIT_C     = 8;
  localparam int H_STD      = 3;
  localparam int H_FAST     = 1;
  localparam logic [31:0] RD_WORD = 32'h0300_0000;

  logic clk, rst_n, por_fast, ncfg_req, status_in, pullup_n, mode_fast, data_in;
  logic status_oe, done_oe, io_tristate, io_pullup_en, user_mode;
  logic sclk, cs_n, cmd_out, bit_out, bit_valid;
  logic ext_hold;

  assign status_in = !status_oe && !ext_hold;

  cfg_sequencer #(
    .TICK_DIV(TICK_DIV), .POR_STD_TICKS(STD_T), .POR_FAST_TICKS(FAST_T),
    .CFG_BITS(NBITS), .INIT_CYCLES(INIT_C),
    .SCLK_HALF_STD(H_STD), .SCLK_HALF_FAST(H_FAST)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .por_fast(por_fast), .ncfg_req(ncfg_req),
    .status_in(status_in), .pullup_n(pullup_n), .mode_fast(mode_fast),
    .status_oe(status_oe), .done_oe(done_oe), .io_tristate(io_tristate),
    .io_pullup_en(io_pullup_en), .user_mode(user_mode), .sclk(sclk),
    .cs_n(cs_n), .cmd_out(cmd_out), .data_in(data_in), .bit_out(bit_out),
    .bit_valid(bit_valid)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit cmd_q[$];
  bit data_q[$];
  bit stream [NBITS];
  int rise_cnt, fall_cnt, t_first, last_period;
  logic sclk_prev = 1'b0;
  logic cs_prev = 1'b1;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic load_frame(input int seed);
    cmd_q.delete();
    data_q.delete();
    for (int i = 0; i < 32; i++) cmd_q.push_back(RD_WORD[31-i]);
    for (int i = 0; i < NBITS; i++) begin
      stream[i] = (((i * 7 + seed) % 3) == 0) ^ i[0];
      data_q.push_back(stream[i]);
    end
  endtask

  // monitor and flash model, all sampled on the falling clock edge
  always @(negedge clk) begin
    if (cs_prev && !cs_n) begin
      rise_cnt = 0;
      fall_cnt = 0;
    end
    if (!cs_n && sclk && !sclk_prev) begin
      if (rise_cnt == 0) t_first = cyc;
      if (rise_cnt == 1) last_period = cyc - t_first;
      if (rise_cnt < 32) begin
        if (cmd_q.size() == 0) check(1'b0, "R4 extra command bit", rise_cnt, 32);
        else begin
          bit e;
          e = cmd_q.pop_front();
          check(cmd_out == e, "R4 command bit", cmd_out, e);
        end
      end
      rise_cnt++;
    end
    if (!cs_n && !sclk && sclk_prev) begin
      fall_cnt++;
      if (fall_cnt >= 32 && fall_cnt - 32 < NBITS) data_in = stream[fall_cnt-32];
    end
    if (bit_valid) begin
      if (data_q.size() == 0) check(1'b0, "R5 unexpected data bit", bit_out, 0);
      else begin
        bit e;
        e = data_q.pop_front();
        check(bit_out == e, "R5 data bit", bit_out, e);
      end
    end
    sclk_prev = sclk;
    cs_prev = cs_n;
  end

  task automatic por_measure(input int ticks, input int lo_ms, input int hi_ms);
    int n;
    n = 0;
    while (status_oe && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(n >= ticks * TICK_DIV + 1 && n <= ticks * TICK_DIV + 5, "R1 POR length", n, ticks * TICK_DIV);
    check(n / TICK_DIV >= lo_ms && n / TICK_DIV <= hi_ms, "R1 POR window ms", n / TICK_DIV, lo_ms);
  endtask

  task automatic wait_done_low();
    int n;
    n = 0;
    while (done_oe && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0; ncfg_req = 1'b1; ext_hold = 1'b1; por_fast = 1'b1;
    pullup_n = 1'b0; mode_fast = 1'b0; data_in = 1'b0;
    load_frame(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(status_oe && done_oe && io_tristate && !io_pullup_en, "R1 POR outputs",
          {status_oe, done_oe, io_tristate, io_pullup_en}, 4'b1110);
    check(cs_n == 1'b1 && user_mode == 1'b0, "R1 reset idle", {cs_n, user_mode}, 2'b10);
    por_measure(FAST_T, 4, 12);
    repeat (10) @(negedge clk);
    check(!status_oe && cs_n, "R2 held by low status line", {status_oe, cs_n}, 2'b01);
    check(io_pullup_en == 1'b1, "R3 pull-up on in reset stage", io_pullup_en, 1);
    ncfg_req = 1'b0;
    @(negedge clk);
    check(status_oe == 1'b1, "R2 status driven while request low", status_oe, 1);
    ncfg_req = 1'b1;
    ext_hold = 1'b0;
    repeat (3) @(negedge clk);
    check(cs_n == 1'b0, "R4 chip select low in config", cs_n, 0);
    wait_done_low();
    check(cs_n == 1'b1, "R7 chip select released at done", cs_n, 1);
    check(last_period == 2 * H_STD, "R6 standard sclk period", last_period, 2 * H_STD);
    n = 0;
    while (!user_mode && n < 100) begin
      if (!io_tristate) check(1'b0, "R7 I/O enabled early", n, INIT_C);
      @(negedge clk);
      n++;
    end
    check(n == INIT_C, "R7 init length", n, INIT_C);
    check(!io_tristate && !io_pullup_en, "R3 R7 user I/O enabled, pull-up off",
          {io_tristate, io_pullup_en}, 0);
    check(cmd_q.size() == 0 && data_q.size() == 0, "R5 frame fully consumed",
          cmd_q.size() + data_q.size(), 0);
    ncfg_req = 1'b0;
    repeat (5) @(negedge clk);
    check(user_mode && !io_tristate && !status_oe, "R9 request ignored in user mode",
          {user_mode, io_tristate, status_oe}, 3'b100);
    ncfg_req = 1'b1;

    rst_n = 1'b0; por_fast = 1'b0; mode_fast = 1'b1; pullup_n = 1'b1;
    load_frame(2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(status_oe && done_oe && io_tristate, "R1 POR outputs second run",
          {status_oe, done_oe, io_tristate}, 3'b111);
    por_measure(STD_T, 100, 300);
    n = 0;
    while (data_q.size() > NBITS - 10 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(io_pullup_en == 1'b0, "R3 pull-up off when pullup_n high", io_pullup_en, 0);
    check(last_period == 2 * H_FAST, "R6 fast sclk period", last_period, 2 * H_FAST);
    ncfg_req = 1'b0;
    @(negedge clk);
    check(cs_n && done_oe && status_oe && !user_mode, "R8 abort in config",
          {cs_n, done_oe, status_oe, user_mode}, 4'b1110);
    repeat (4) @(negedge clk);
    load_frame(3);
    ncfg_req = 1'b1;
    wait_done_low();
    check(done_oe == 1'b0, "R8 restarted frame completes", done_oe, 0);
    ncfg_req = 1'b0;
    @(negedge clk);
    check(done_oe && status_oe && !user_mode && io_tristate, "R8 abort in init",
          {done_oe, status_oe, user_mode, io_tristate}, 4'b1101);
    repeat (3) @(negedge clk);
    load_frame(4);
    ncfg_req = 1'b1;
    n = 0;
    while (!user_mode && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(user_mode == 1'b1, "R7 user mode after reload", user_mode, 1);
    check(cmd_q.size() == 0 && data_q.size() == 0, "R8 full command resent",
          cmd_q.size() + data_q.size(), 0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    summary();
  end
endmodule